// File: doc/BRIEF.md
# LCD Panel Raster Timing Generator

This block produces the scan timing for a raster LCD panel: a pixel clock enable and a pixel clock waveform, horizontal and vertical sync, a data-enable level, a per-pixel fetch strobe for the active area, and the current pixel and line counters. Three 32-bit settings words configure it. One word describes the horizontal line, one describes the vertical frame, and the third carries the pixel clock divider and the output polarity controls. A panel-type input selects between active-matrix and passive panels, and this choice sets the lowest divider the block will use.

Each line and each frame runs in a fixed order: active region, front porch, sync, back porch. The settings words are captured at the start of every frame, so a write in the middle of a frame never disturbs the frame being scanned. While the enable input is high the block scans frame after frame. When enable is dropped, the frame in progress is completed, scanning stops, and a one-cycle done pulse follows. A frame fetch engine uses the strobe and the counters to move pixel data, and uses the done pulse to know when it can safely reprogram.

Top module: `lcd_raster_timing`

## Requirements
- R1: After reset the block is idle. pix_valid_o and frame_done_o are 0, both counters are 0, hsync_o and vsync_o sit at their inactive level (1 with default polarity), de_o is 0 and pclk_o is 0.
- R2: Horizontal word: bits 9:0 give active pixels minus 1, bits 15:10 sync width minus 1, bits 23:16 front porch minus 1, and bits 31:24 back porch minus 1, all counted in pixel clocks. Each line has exactly (field+1) strobes, and hsync is active for (sync field+1) pixel periods.
- R3: Vertical word: bits 9:0 give active lines minus 1 and bits 15:10 sync lines minus 1. Bits 23:16 (front porch) and bits 31:24 (back porch) are literal line counts. A frame lasts line length × (active + front porch + sync + back porch) pixel periods, and vsync covers (sync field+1) whole lines.
- R4: The pixel clock period in cycles is bits 7:0 of the control word, raised to at least 2 when tft_i=1 and at least 3 when tft_i=0. The maximum is 255. pix_ce_o pulses once per period and never on two cycles in a row.
- R5: pix_valid_o pulses on the last cycle of each pixel period, and only inside the active area. Strobes run in row-major order, and the counters show the pixel being strobed. de_o is active throughout the active area.
- R6: Control word bit 20 set makes vsync_o active high, bit 21 set makes hsync_o active high, and bit 23 set makes de_o active low. With these bits clear, both syncs are active low and de_o is active high.
- R7: Control word bit 22 selects the pixel clock phase. On every pix_ce_o cycle pclk_o is 1 when the bit is 0 and 0 when it is 1. When idle, pclk_o equals the bit.
- R8: When enable_i falls during a frame, that frame completes. frame_done_o is 1 on the cycle right after the final pixel period of the last back porch line, and the block is then idle.
- R9: frame_done_o lasts exactly one cycle and does not occur while enable_i stays high.
- R10: The settings words are captured at each frame start. A change in the middle of a frame takes effect only from the next frame.
- R11: Control word bits 24 and 25 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Scan enable; when dropped, scanning stops at the next frame end |
| tft_i | input | 1 | 1 = active-matrix panel (divider floor 2), 0 = passive panel (divider floor 3) |
| htiming_i | input | 32 | Horizontal settings word |
| vtiming_i | input | 32 | Vertical settings word |
| ctiming_i | input | 32 | Divider and polarity settings word |
| pix_ce_o | output | 1 | One-cycle pixel clock enable |
| pclk_o | output | 1 | Pixel clock waveform |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pix_valid_o | output | 1 | Pixel fetch strobe for the active area |
| pix_x_o | output | 12 | Pixel counter within the line |
| line_y_o | output | 12 | Line counter within the frame |
| frame_done_o | output | 1 | One-cycle pulse after the last frame following disable |

## Verification
Several properties are checked on every cycle:
- pixel clock enables never fall on two cycles in a row;
- strobes appear only while both axes are in their active regions;
- each counter wraps to zero right after its last position;
- the sync span never overlaps the active span;
- the done pulse is a single cycle and coincides with the fall of the running state;
- the captured settings stay stable inside a frame.

Only the bench scenarios can show the rest:
- the exact field decoding, including the mixed minus-one and literal encodings, which shows up as measured sync widths and frame lengths;
- the divider floor for each panel type;
- the polarity and phase bits;
- the row-major strobe order;
- the exact cycle on which the deferred stop finishes.

// File: rtl/lrt_pkg.sv
package lrt_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 12;
  localparam int DIV_W  = 8;

  localparam int BIT_VS_POL    = 20;
  localparam int BIT_HS_POL    = 21;
  localparam int BIT_PCLK_EDGE = 22;
  localparam int BIT_DE_POL    = 23;

  localparam logic [DIV_W-1:0] DIV_FLOOR_TFT = DIV_W'(2);
  localparam logic [DIV_W-1:0] DIV_FLOOR_PAS = DIV_W'(3);

  typedef struct packed {
    logic [CNT_W-1:0] act_end;
    logic [CNT_W-1:0] sync_beg;
    logic [CNT_W-1:0] sync_end;
    logic [CNT_W-1:0] last;
  } axis_cfg_t;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             vs_pol;
    logic             hs_pol;
    logic             pclk_inv;
    logic             de_pol;
  } ctl_cfg_t;

  // Horizontal fields are all stored minus one
  function automatic axis_cfg_t decode_h(input logic [WORD_W-1:0] w);
    axis_cfg_t c;
    logic [CNT_W-1:0] act, sw, fp, bp;
    act = CNT_W'(w[9:0])   + CNT_W'(1);
    sw  = CNT_W'(w[15:10]) + CNT_W'(1);
    fp  = CNT_W'(w[23:16]) + CNT_W'(1);
    bp  = CNT_W'(w[31:24]) + CNT_W'(1);
    c.act_end  = act;
    c.sync_beg = act + fp;
    c.sync_end = act + fp + sw;
    c.last     = act + fp + sw + bp - CNT_W'(1);
    return c;
  endfunction

  // Vertical porches are literal line counts
  function automatic axis_cfg_t decode_v(input logic [WORD_W-1:0] w);
    axis_cfg_t c;
    logic [CNT_W-1:0] act, sw, fp, bp;
    act = CNT_W'(w[9:0])   + CNT_W'(1);
    sw  = CNT_W'(w[15:10]) + CNT_W'(1);
    fp  = CNT_W'(w[23:16]);
    bp  = CNT_W'(w[31:24]);
    c.act_end  = act;
    c.sync_beg = act + fp;
    c.sync_end = act + fp + sw;
    c.last     = act + fp + sw + bp - CNT_W'(1);
    return c;
  endfunction

  function automatic ctl_cfg_t decode_ctl(input logic [WORD_W-1:0] w, input logic tft);
    ctl_cfg_t c;
    logic [DIV_W-1:0] floor_v;
    floor_v    = tft ? DIV_FLOOR_TFT : DIV_FLOOR_PAS;
    c.div      = (w[DIV_W-1:0] < floor_v) ? floor_v : w[DIV_W-1:0];
    c.vs_pol   = w[BIT_VS_POL];
    c.hs_pol   = w[BIT_HS_POL];
    c.pclk_inv = w[BIT_PCLK_EDGE];
    c.de_pol   = w[BIT_DE_POL];
    return c;
  endfunction
endpackage

// File: rtl/lrt_pix_div.sv
module lrt_pix_div
  import lrt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             inv_i,
  output logic             ce_o,
  output logic             pclk_o
);
  logic [DIV_W-1:0] dcnt_q;
  logic             wrap;

  assign wrap = (dcnt_q == div_i - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dcnt_q <= '0;
    else if (!run_i)  dcnt_q <= '0;
    else if (wrap)    dcnt_q <= '0;
    else              dcnt_q <= dcnt_q + DIV_W'(1);
  end

  assign ce_o   = run_i & wrap;
  // high half ends with the enable cycle
  assign pclk_o = run_i ? ((dcnt_q >= (div_i >> 1)) ^ inv_i) : inv_i;

  a_r4_ce_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_o |=> !ce_o);
endmodule

// File: rtl/lrt_axis.sv
module lrt_axis
  import lrt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  axis_cfg_t        cfg_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             act_o,
  output logic             sync_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (step_i)  cnt_q <= last_o ? '0 : cnt_q + CNT_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign act_o  = cnt_q < cfg_i.act_end;
  assign sync_o = (cnt_q >= cfg_i.sync_beg) && (cnt_q < cfg_i.sync_end);
  assign last_o = cnt_q == cfg_i.last;

  a_r2_wrap_at_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && last_o && !clr_i) |=> (cnt_o == '0));
  a_r3_sync_outside_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> !act_o);
endmodule

// File: rtl/lrt_frame_ctrl.sv
module lrt_frame_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic frame_end_i,
  output logic run_o,
  output logic load_o,
  output logic done_o
);
  logic run_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= run_q & frame_end_i & ~enable_i;
      if (!run_q && enable_i)                      run_q <= 1'b1;
      else if (run_q && frame_end_i && !enable_i)  run_q <= 1'b0;
    end
  end

  assign run_o  = run_q;
  assign load_o = ~run_q | frame_end_i;
  assign done_o = done_q;

  a_r9_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_idle_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !run_o);
  a_r8_stop_gives_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_o) |-> done_o);
endmodule

// File: rtl/lcd_raster_timing.sv
module lcd_raster_timing
  import lrt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              tft_i,
  input  logic [WORD_W-1:0] htiming_i,
  input  logic [WORD_W-1:0] vtiming_i,
  input  logic [WORD_W-1:0] ctiming_i,
  output logic              pix_ce_o,
  output logic              pclk_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              pix_valid_o,
  output logic [CNT_W-1:0]  pix_x_o,
  output logic [CNT_W-1:0]  line_y_o,
  output logic              frame_done_o
);
  axis_cfg_t h_cfg_q, v_cfg_q;
  ctl_cfg_t  c_cfg_q;
  logic run, load, ce, frame_end;
  logic h_act, h_sync, h_last, v_act, v_sync, v_last;
  logic de_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_cfg_q <= '0;
      v_cfg_q <= '0;
      c_cfg_q <= '0;
    end else if (load) begin
      h_cfg_q <= decode_h(htiming_i);
      v_cfg_q <= decode_v(vtiming_i);
      c_cfg_q <= decode_ctl(ctiming_i, tft_i);
    end
  end

  lrt_pix_div u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div_i  (c_cfg_q.div),
    .inv_i  (c_cfg_q.pclk_inv),
    .ce_o   (ce),
    .pclk_o (pclk_o)
  );

  lrt_axis u_h (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (~run),
    .step_i (ce),
    .cfg_i  (h_cfg_q),
    .cnt_o  (pix_x_o),
    .act_o  (h_act),
    .sync_o (h_sync),
    .last_o (h_last)
  );

  lrt_axis u_v (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (~run),
    .step_i (ce & h_last),
    .cfg_i  (v_cfg_q),
    .cnt_o  (line_y_o),
    .act_o  (v_act),
    .sync_o (v_sync),
    .last_o (v_last)
  );

  assign frame_end = ce & h_last & v_last;

  lrt_frame_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .frame_end_i (frame_end),
    .run_o       (run),
    .load_o      (load),
    .done_o      (frame_done_o)
  );

  assign de_lvl       = run & h_act & v_act;
  assign pix_ce_o     = ce;
  assign pix_valid_o  = ce & de_lvl;
  assign hsync_o      = c_cfg_q.hs_pol ? (run & h_sync) : ~(run & h_sync);
  assign vsync_o      = c_cfg_q.vs_pol ? (run & v_sync) : ~(run & v_sync);
  assign de_o         = c_cfg_q.de_pol ? ~de_lvl : de_lvl;

  a_r5_valid_in_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> (run && h_act && v_act));
  a_r10_cfg_held_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && $past(run) && !$past(frame_end)) |-> ($stable(h_cfg_q) && $stable(v_cfg_q) && $stable(c_cfg_q)));
endmodule

// File: tb/lcd_raster_timing_tb.sv
`timescale 1ns/1ps
module lcd_raster_timing_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic enable_i = 1'b0;
  logic tft_i = 1'b1;
  logic [31:0] htiming_i, vtiming_i, ctiming_i;
  logic pix_ce_o, pclk_o, hsync_o, vsync_o, de_o, pix_valid_o, frame_done_o;
  logic [11:0] pix_x_o, line_y_o;

  localparam logic [31:0] H_A = 32'h0000_0403; // 4 act, 2 sync, 1 fp, 1 bp -> 8
  localparam logic [31:0] H_B = 32'h0000_0405; // 6 act -> 10
  localparam logic [31:0] V_A = 32'h0101_0002; // 3 act, fp 1, sync 1, bp 1 -> 6

  int n_checks = 0, n_fail = 0;
  int exp_q[$];
  bit sb_on = 0;
  int sb_hits = 0;

  always #4 clk_i = ~clk_i;

  lcd_raster_timing u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .tft_i(tft_i),
    .htiming_i(htiming_i), .vtiming_i(vtiming_i), .ctiming_i(ctiming_i),
    .pix_ce_o(pix_ce_o), .pclk_o(pclk_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .de_o(de_o), .pix_valid_o(pix_valid_o), .pix_x_o(pix_x_o), .line_y_o(line_y_o),
    .frame_done_o(frame_done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_frame(input int ppl, input int lpf);
    for (int y = 0; y < lpf; y++)
      for (int x = 0; x < ppl; x++) exp_q.push_back(x * 4096 + y);
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (sb_on && pix_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(0, "R5 unexpected strobe", int'(pix_x_o), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        sb_hits++;
        chk((int'(pix_x_o) * 4096 + int'(line_y_o)) == e, "R5 strobe order",
            int'(pix_x_o) * 4096 + int'(line_y_o), e);
        chk(de_o == 1'b1, "R5 de during strobe", int'(de_o), 1);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  task automatic stop_wait(output int n);
    enable_i = 1'b0;
    n = 0;
    do begin @(negedge clk_i); n++; end while (!frame_done_o && n < 40000);
  endtask

  task automatic ce_gap(output int n);
    while (!pix_ce_o) @(negedge clk_i);
    n = 0;
    do begin @(negedge clk_i); n++; end while (!pix_ce_o);
  endtask

  task automatic hs_width(input logic lvl, output int n);
    while (hsync_o == lvl) @(negedge clk_i);
    while (hsync_o != lvl) @(negedge clk_i);
    n = 0;
    while (hsync_o == lvl) begin @(negedge clk_i); n++; end
  endtask

  task automatic vs_width(input logic lvl, output int n);
    while (vsync_o == lvl) @(negedge clk_i);
    while (vsync_o != lvl) @(negedge clk_i);
    n = 0;
    while (vsync_o == lvl) begin @(negedge clk_i); n++; end
  endtask

  task automatic wait_origin();
    do @(negedge clk_i); while (!(pix_valid_o && pix_x_o == 0 && line_y_o == 0));
  endtask

  task automatic origin_gap(output int n);
    n = 0;
    do begin @(negedge clk_i); n++; end
      while (!(pix_valid_o && pix_x_o == 0 && line_y_o == 0));
  endtask

  task automatic idle_cfg(input logic [31:0] h, input logic [31:0] c, input logic t);
    htiming_i = h;
    ctiming_i = c;
    tft_i     = t;
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    int n;
    htiming_i = H_A;
    vtiming_i = V_A;
    ctiming_i = 32'h0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(pix_valid_o == 0 && frame_done_o == 0, "R1 strobes idle", int'(pix_valid_o), 0);
    chk(pix_x_o == 0 && line_y_o == 0, "R1 counters", int'(pix_x_o) + int'(line_y_o), 0);
    chk(hsync_o == 1 && vsync_o == 1, "R1 sync inactive", int'(hsync_o) + int'(vsync_o), 2);
    chk(de_o == 0 && pclk_o == 0, "R1 de and pclk", int'(de_o) + int'(pclk_o), 0);

    // R5 R8 R9: one frame through the scoreboard, deferred stop
    push_frame(4, 3);
    sb_on = 1;
    enable_i = 1'b1;
    n = 0;
    do begin
      @(negedge clk_i); n++;
      if (n == 10) enable_i = 1'b0;
    end while (!frame_done_o && n < 1000);
    chk(n == 97, "R8 done after final period", n, 97);
    chk(sb_hits == 12 && exp_q.size() == 0, "R5 strobe count", sb_hits, 12);
    @(negedge clk_i);
    chk(frame_done_o == 0, "R9 done one cycle", int'(frame_done_o), 0);
    repeat (30) @(negedge clk_i);
    chk(pix_x_o == 0 && line_y_o == 0 && hsync_o == 1, "R8 idle after done", int'(pix_x_o), 0);
    sb_on = 0;

    // continuous scan with config A
    enable_i = 1'b1;
    hs_width(1'b0, n);  chk(n == 4,  "R2 hsync width", n, 4);
    vs_width(1'b0, n);  chk(n == 16, "R3 vsync width", n, 16);
    wait_origin();
    origin_gap(n);      chk(n == 96, "R3 frame length", n, 96);
    ce_gap(n);          chk(n == 2,  "R4 tft floor", n, 2);
    while (!pix_ce_o) @(negedge clk_i);
    chk(pclk_o == 1, "R7 pclk phase default", int'(pclk_o), 1);
    n = 0;
    repeat (300) begin @(negedge clk_i); if (frame_done_o) n++; end
    chk(n == 0, "R9 no done while enabled", n, 0);

    // R10 mid-frame change
    wait_origin();
    n = 0;
    repeat (10) begin @(negedge clk_i); n++; end
    htiming_i = H_B;
    do begin @(negedge clk_i); n++; end
      while (!(pix_valid_o && pix_x_o == 0 && line_y_o == 0));
    chk(n == 96, "R10 current frame unchanged", n, 96);
    origin_gap(n);      chk(n == 120, "R10 next frame uses new word", n, 120);
    stop_wait(n);
    chk(frame_done_o == 1, "R8 stop reached", int'(frame_done_o), 1);

    // R4 divider floor per panel type
    begin
      int raw_l[6] = '{0, 0, 1, 2, 7, 255};
      bit tft_l[6] = '{1, 0, 0, 1, 1, 0};
      int exp_l[6] = '{2, 3, 3, 2, 7, 255};
      for (int i = 0; i < 6; i++) begin
        idle_cfg(H_A, 32'(raw_l[i]), tft_l[i]);
        enable_i = 1'b1;
        ce_gap(n);
        chk(n == exp_l[i], "R4 divider", n, exp_l[i]);
        stop_wait(n);
      end
    end

    // R6 polarity bits
    idle_cfg(H_A, 32'h00B0_0000, 1'b1);
    chk(hsync_o == 0 && vsync_o == 0, "R6 idle syncs active-high", int'(hsync_o) + int'(vsync_o), 0);
    chk(de_o == 1, "R6 idle de active-low", int'(de_o), 1);
    enable_i = 1'b1;
    hs_width(1'b1, n);  chk(n == 4,  "R6 hsync high width", n, 4);
    vs_width(1'b1, n);  chk(n == 16, "R6 vsync high width", n, 16);
    stop_wait(n);

    // R7 pixel clock phase
    idle_cfg(H_A, 32'h0040_0000, 1'b1);
    chk(pclk_o == 1, "R7 idle pclk inverted", int'(pclk_o), 1);
    enable_i = 1'b1;
    ce_gap(n);
    chk(pclk_o == 0, "R7 pclk at enable inverted", int'(pclk_o), 0);
    stop_wait(n);

    // R11 bits 24 and 25 ignored
    idle_cfg(H_A, 32'h0300_0000, 1'b1);
    chk(hsync_o == 1 && vsync_o == 1 && de_o == 0 && pclk_o == 0, "R11 idle levels",
        int'({hsync_o, vsync_o, de_o, pclk_o}), 12);
    enable_i = 1'b1;
    hs_width(1'b0, n);  chk(n == 4, "R11 hsync width", n, 4);
    wait_origin();
    origin_gap(n);      chk(n == 96, "R11 frame length", n, 96);
    stop_wait(n);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule